// File: doc/BRIEF.md
# Patrol and Demand Memory Scrubber

This block works next to the request arbiter of a memory controller. It keeps DRAM soft errors from building up over time. A patrol walker steps through a programmed address window, from a base address to a limit address. After each programmable idle gap it issues a background read. Every read that returns to the controller carries a status from the ECC decoder, and the scrubber watches that status whether the read was a patrol read or a normal demand read.

When the decoder reports a correctable error, the scrubber queues one write of the corrected word back to the failing address. It drops that write if another agent writes the same address, either in the same cycle or before the write-back is granted. An uncorrectable error is never written back. The block only records it. If the uncorrectable error was found by a patrol read, it is recorded as speculative, because no agent has consumed the bad data yet.

A single log holds the first error seen, together with a sticky overflow flag, and is cleared by a write-1 pulse. A per-kind mask selects which logged error kinds raise the interrupt line.

Top module: `mem_scrub_ctrl`

## Requirements
- R1: With `cfg_en` high, patrol reads target only addresses from `cfg_base` to `cfg_limit`. They start at `cfg_base`, go up by one per read, and return to `cfg_base` after the read at `cfg_limit`.
- R2: `pass_done` is high for exactly one cycle, in the cycle after the patrol read of `cfg_limit` is accepted.
- R3: With `req_ready` held high, patrol reads are accepted every `cfg_interval`+2 cycles.
- R4: A response with `rsp_ecc`=1 (correctable), arriving when no write-back is pending, makes `req_valid`/`req_write` high in the next cycle. The request carries `req_addr`=`rsp_addr` and `req_wdata`=`rsp_data`. This holds for both patrol and demand responses.
- R5: No write-back is issued if `snp_wr_valid` shows the same address in the response cycle, or at any time while the write-back waits for `req_ready`.
- R6: A response with `rsp_ecc`=2 (uncorrectable) never causes a write-back. It is logged with kind 3 (speculative) when `rsp_scrub`=1 and kind 2 (demand) when `rsp_scrub`=0. A correctable error logs kind 1, and `rsp_ecc`=0 logs nothing.
- R7: The log keeps the address and kind of the first error until cleared. A later error sets the sticky `log_ovf` instead. A `log_clr` pulse clears `log_valid` and `log_ovf`.
- R8: A pending write-back is presented ahead of a pending patrol read, and the patrol read follows once the write-back is accepted.
- R9: Only one write-back is outstanding at a time. A correctable error that arrives while one is pending is logged only, and the pending request keeps its address and data.
- R10: `err_irq` is high while `log_valid` is high and bit (`log_kind`-1) of `cfg_irq_mask` is set.
- R11: After reset, `req_valid`, `log_valid`, `log_ovf`, `pass_done` and `err_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Patrol walker enable; low parks the walker at `cfg_base` |
| cfg_base | input | AW | First address of the patrol window |
| cfg_limit | input | AW | Last address of the patrol window |
| cfg_interval | input | IW | Idle cycles between patrol reads |
| cfg_irq_mask | input | 3 | Interrupt enable per log kind (bit kind-1) |
| req_valid | output | 1 | Request to the arbiter |
| req_ready | input | 1 | Arbiter accepts the request this cycle |
| req_write | output | 1 | 1 = corrective write, 0 = patrol read |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Corrected write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_scrub | input | 1 | Response belongs to a patrol read |
| rsp_addr | input | AW | Response address |
| rsp_ecc | input | 2 | 0 clean, 1 correctable, 2 uncorrectable |
| rsp_data | input | DW | Corrected read data |
| snp_wr_valid | input | 1 | Another agent's write is in flight |
| snp_wr_addr | input | AW | Address of that write |
| log_clr | input | 1 | Write-1 clear of the error log |
| log_valid | output | 1 | Log holds an error |
| log_addr | output | AW | Address of the first logged error |
| log_kind | output | 2 | 1 correctable, 2 demand uncorrectable, 3 speculative |
| log_ovf | output | 1 | Sticky: further errors arrived after the first |
| err_irq | output | 1 | Masked error interrupt |
| pass_done | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The checker watches these rules on every cycle:
- patrol addresses stay inside the window;
- the pass pulse lasts one cycle;
- a correctable response with no collision leads to a write-back one cycle later, at the response address;
- an uncorrectable response never starts a write;
- a pending write-back holds steady until it is granted or snooped away;
- the log contents and the overflow flag stay sticky.

Other behaviours need the bench's scenarios:
- the exact read spacing set by the interval;
- the wrap sequence;
- the kind chosen for each response class;
- cancellation by a snoop that arrives after the write-back was queued;
- the ordering of a write-back against an already pending patrol read;
- the interrupt mask.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam logic [1:0] ECC_CLEAN  = 2'd0;
  localparam logic [1:0] ECC_CORR   = 2'd1;
  localparam logic [1:0] ECC_UNCORR = 2'd2;

  localparam logic [1:0] KIND_NONE    = 2'd0;
  localparam logic [1:0] KIND_CE      = 2'd1;
  localparam logic [1:0] KIND_UE_DEM  = 2'd2;
  localparam logic [1:0] KIND_UE_SPEC = 2'd3;

  // Log kind for one response: patrol-found uncorrectable errors are speculative
  function automatic logic [1:0] err_kind(input logic patrol, input logic [1:0] ecc);
    if (ecc == ECC_CORR)   return KIND_CE;
    if (ecc == ECC_UNCORR) return patrol ? KIND_UE_SPEC : KIND_UE_DEM;
    return KIND_NONE;
  endfunction
endpackage

// File: rtl/scrub_walker.sv
module scrub_walker #(
  parameter int AW = 16,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic [IW-1:0] interval,
  input  logic          issue,
  output logic          pend,
  output logic [AW-1:0] addr,
  output logic          pass_done
);
  logic [IW-1:0] gap_cnt;

  // Next patrol address; anything at or past the limit, or below base, restarts at base
  function automatic logic [AW-1:0] step(input logic [AW-1:0] cur,
                                         input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    return (cur >= hi || cur < lo) ? lo : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      pend      <= 1'b0;
      addr      <= '0;
      pass_done <= 1'b0;
    end else begin
      pass_done <= 1'b0;
      if (!en) begin
        gap_cnt <= '0;
        pend    <= 1'b0;
        addr    <= base;
      end else if (pend) begin
        if (issue) begin
          pend      <= 1'b0;
          addr      <= step(addr, base, limit);
          pass_done <= (addr == limit);
        end
      end else if (gap_cnt >= interval) begin
        pend    <= 1'b1;
        gap_cnt <= '0;
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scrub_wb_ctrl.sv
module scrub_wb_ctrl
  import scrub_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsp_valid,
  input  logic [1:0]    rsp_ecc,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_data,
  input  logic          snp_hit_rsp,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic          wb_fire,
  output logic          busy,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data
);
  logic ce_seen;
  logic hit_pending;

  assign ce_seen     = rsp_valid && (rsp_ecc == ECC_CORR);
  assign hit_pending = busy && snp_valid && (snp_addr == wb_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
    end else if (busy) begin
      if (wb_fire || hit_pending) busy <= 1'b0;
    end else if (ce_seen && !snp_hit_rsp) begin
      busy    <= 1'b1;
      wb_addr <= rsp_addr;
      wb_data <= rsp_data;
    end
  end
endmodule

// File: rtl/scrub_errlog.sv
module scrub_errlog
  import scrub_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsp_valid,
  input  logic          rsp_scrub,
  input  logic [1:0]    rsp_ecc,
  input  logic [AW-1:0] rsp_addr,
  input  logic          clr,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [1:0]    kind,
  output logic          ovf
);
  logic [1:0] new_kind;
  logic       new_err;

  assign new_kind = err_kind(rsp_scrub, rsp_ecc);
  assign new_err  = rsp_valid && (new_kind != KIND_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      kind  <= KIND_NONE;
      ovf   <= 1'b0;
    end else begin
      if (clr) begin
        valid <= 1'b0;
        ovf   <= 1'b0;
      end
      if (new_err) begin
        if (!valid || clr) begin
          valid <= 1'b1;
          addr  <= rsp_addr;
          kind  <= new_kind;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mem_scrub_ctrl.sv
module mem_scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic [IW-1:0] cfg_interval,
  input  logic [2:0]    cfg_irq_mask,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic          rsp_scrub,
  input  logic [AW-1:0] rsp_addr,
  input  logic [1:0]    rsp_ecc,
  input  logic [DW-1:0] rsp_data,
  input  logic          snp_wr_valid,
  input  logic [AW-1:0] snp_wr_addr,
  input  logic          log_clr,
  output logic          log_valid,
  output logic [AW-1:0] log_addr,
  output logic [1:0]    log_kind,
  output logic          log_ovf,
  output logic          err_irq,
  output logic          pass_done
);
  // Internal events brought out as named wires for the checker
  logic          wb_busy;
  logic          patrol_pend;
  logic          snp_hit_rsp;
  logic          wb_fire;
  logic          patrol_fire;
  logic [AW-1:0] patrol_addr;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  assign snp_hit_rsp = snp_wr_valid && (snp_wr_addr == rsp_addr);
  assign wb_fire     = wb_busy && req_ready;
  assign patrol_fire = !wb_busy && patrol_pend && req_ready;

  assign req_valid = wb_busy || patrol_pend;
  assign req_write = wb_busy;
  assign req_addr  = wb_busy ? wb_addr : patrol_addr;
  assign req_wdata = wb_busy ? wb_data : '0;

  scrub_walker #(.AW(AW), .IW(IW)) u_walker (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .base(cfg_base), .limit(cfg_limit),
    .interval(cfg_interval), .issue(patrol_fire), .pend(patrol_pend),
    .addr(patrol_addr), .pass_done(pass_done)
  );

  scrub_wb_ctrl #(.AW(AW), .DW(DW)) u_wb (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ecc(rsp_ecc),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data), .snp_hit_rsp(snp_hit_rsp),
    .snp_valid(snp_wr_valid), .snp_addr(snp_wr_addr), .wb_fire(wb_fire),
    .busy(wb_busy), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  scrub_errlog #(.AW(AW)) u_log (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_scrub(rsp_scrub),
    .rsp_ecc(rsp_ecc), .rsp_addr(rsp_addr), .clr(log_clr), .valid(log_valid),
    .addr(log_addr), .kind(log_kind), .ovf(log_ovf)
  );

  always_comb begin
    err_irq = 1'b0;
    if (log_valid && log_kind != KIND_NONE) err_irq = cfg_irq_mask[log_kind - 2'd1];
  end
endmodule

// File: rtl/scrub_chk.sv
module scrub_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [AW-1:0] cfg_base,
  input logic [AW-1:0] cfg_limit,
  input logic          rsp_valid,
  input logic [1:0]    rsp_ecc,
  input logic [AW-1:0] rsp_addr,
  input logic          snp_wr_valid,
  input logic [AW-1:0] snp_wr_addr,
  input logic          snp_hit_rsp,
  input logic          wb_busy,
  input logic          pass_done,
  input logic          log_valid,
  input logic          log_clr,
  input logic [AW-1:0] log_addr,
  input logic [1:0]    log_kind,
  input logic          log_ovf
);
  a_r1_patrol_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |-> (req_addr >= cfg_base && req_addr <= cfg_limit));

  a_r2_pass_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);

  a_r4_ce_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ecc == 2'd1 && !wb_busy && !snp_hit_rsp)
      |=> (req_valid && req_write && req_addr == $past(rsp_addr)));

  a_r6_ue_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ecc == 2'd2 && !wb_busy) |=> !(req_valid && req_write));

  a_r9_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_busy && !req_ready && !(snp_wr_valid && snp_wr_addr == req_addr))
      |=> (wb_busy && $stable(req_addr)));

  a_r7_log_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_clr) |=> (log_valid && $stable(log_addr) && $stable(log_kind)));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (log_ovf && !log_clr) |=> log_ovf);
endmodule

bind mem_scrub_ctrl scrub_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .cfg_base(cfg_base),
  .cfg_limit(cfg_limit), .rsp_valid(rsp_valid), .rsp_ecc(rsp_ecc),
  .rsp_addr(rsp_addr), .snp_wr_valid(snp_wr_valid), .snp_wr_addr(snp_wr_addr),
  .snp_hit_rsp(snp_hit_rsp), .wb_busy(wb_busy), .pass_done(pass_done),
  .log_valid(log_valid), .log_clr(log_clr), .log_addr(log_addr),
  .log_kind(log_kind), .log_ovf(log_ovf)
);

// File: tb/mem_scrub_ctrl_tb_top.sv
module mem_scrub_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_limit = '0;
  logic [IW-1:0] cfg_interval = '0;
  logic [2:0]    cfg_irq_mask = 3'b111;
  logic          req_valid, req_write;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid = 1'b0, rsp_scrub = 1'b0;
  logic [AW-1:0] rsp_addr = '0;
  logic [1:0]    rsp_ecc = 2'd0;
  logic [DW-1:0] rsp_data = '0;
  logic          snp_wr_valid = 1'b0;
  logic [AW-1:0] snp_wr_addr = '0;
  logic          log_clr = 1'b0;
  logic          log_valid, log_ovf, err_irq, pass_done;
  logic [AW-1:0] log_addr;
  logic [1:0]    log_kind;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mem_scrub_ctrl #(.AW(AW), .DW(DW), .IW(IW)) dut_i (.*);

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // snp: 0 none, 1 same address, 2 other address
  typedef struct packed {
    logic          scrub;
    logic [1:0]    ecc;
    logic [1:0]    snp;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          exp_wb;
    logic [1:0]    exp_kind;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 2'd1, 2'd0, 16'h0010, 32'hA5A5_0001, 1'b1, 2'd1},
    '{1'b1, 2'd1, 2'd0, 16'h0020, 32'hA5A5_0002, 1'b1, 2'd1},
    '{1'b0, 2'd1, 2'd1, 16'h0030, 32'hA5A5_0003, 1'b0, 2'd1},
    '{1'b0, 2'd2, 2'd0, 16'h0040, 32'hA5A5_0004, 1'b0, 2'd2},
    '{1'b1, 2'd2, 2'd0, 16'h0050, 32'hA5A5_0005, 1'b0, 2'd3},
    '{1'b0, 2'd0, 2'd0, 16'h0060, 32'hA5A5_0006, 1'b0, 2'd0},
    '{1'b0, 2'd1, 2'd2, 16'h0070, 32'hA5A5_0007, 1'b1, 2'd1}
  };

  task automatic send_rsp(input logic scrub, input logic [1:0] ecc,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_scrub = scrub; rsp_ecc = ecc; rsp_addr = a; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0; snp_wr_valid = 1'b0;
  endtask

  task automatic clear_all();
    log_clr = 1'b1; req_ready = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; req_ready = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "req_valid", 64'(req_valid), 64'd0);
    check("R11", "log_valid", 64'(log_valid), 64'd0);
    check("R11", "log_ovf",   64'(log_ovf),   64'd0);
    check("R11", "pass_done", 64'(pass_done), 64'd0);
    check("R11", "err_irq",   64'(err_irq),   64'd0);

    // Table walk: R4, R5, R6, R10 with walker disabled
    foreach (VECS[i]) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_scrub = VECS[i].scrub; rsp_ecc = VECS[i].ecc;
      rsp_addr = VECS[i].addr; rsp_data = VECS[i].data;
      snp_wr_valid = (VECS[i].snp != 2'd0);
      snp_wr_addr  = (VECS[i].snp == 2'd1) ? VECS[i].addr : VECS[i].addr + 16'd1;
      @(negedge clk);
      rsp_valid = 1'b0; snp_wr_valid = 1'b0;
      check(VECS[i].exp_wb ? "R4" : "R5/R6", "write-back", 64'(req_valid && req_write), 64'(VECS[i].exp_wb));
      if (VECS[i].exp_wb) begin
        check("R4", "wb addr", 64'(req_addr), 64'(VECS[i].addr));
        check("R4", "wb data", 64'(req_wdata), 64'(VECS[i].data));
      end
      check("R6", "log_valid", 64'(log_valid), 64'(VECS[i].exp_kind != 2'd0));
      if (VECS[i].exp_kind != 2'd0) begin
        check("R6", "log_kind", 64'(log_kind), 64'(VECS[i].exp_kind));
        check("R7", "log_addr", 64'(log_addr), 64'(VECS[i].addr));
      end
      check("R10", "err_irq", 64'(err_irq), 64'(VECS[i].exp_kind != 2'd0));
      clear_all();
      check("R7", "cleared", 64'(log_valid || req_valid), 64'd0);
    end

    // R1/R2/R3: patrol walk over 4..6 with interval 2
    begin
      logic [AW-1:0] seen [4];
      int            at   [4];
      int            n = 0, cyc = 0, passes = 0;
      cfg_base = 16'd4; cfg_limit = 16'd6; cfg_interval = 12'd2;
      @(negedge clk);
      req_ready = 1'b1; cfg_en = 1'b1;
      while (n < 4 && cyc < 100) begin
        @(negedge clk);
        cyc++;
        if (pass_done) passes++;
        if (req_valid && !req_write) begin
          seen[n] = req_addr; at[n] = cyc; n++;
        end
      end
      cfg_en = 1'b0; req_ready = 1'b0;
      check("R1", "reads seen", 64'(n), 64'd4);
      check("R1", "read0", 64'(seen[0]), 64'd4);
      check("R1", "read1", 64'(seen[1]), 64'd5);
      check("R1", "read2", 64'(seen[2]), 64'd6);
      check("R1", "wrap read3", 64'(seen[3]), 64'd4);
      check("R2", "pass pulses", 64'(passes), 64'd1);
      for (int k = 1; k < 4; k++) check("R3", "read gap", 64'(at[k] - at[k-1]), 64'd4);
    end

    // R8: write-back presented ahead of a pending patrol read
    @(negedge clk);
    cfg_interval = 12'd0; cfg_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", "patrol pending", 64'(req_valid && !req_write), 64'd1);
    send_rsp(1'b0, 2'd1, 16'h0100, 32'hBEEF_0100);
    check("R8", "write first", 64'(req_valid && req_write), 64'd1);
    check("R8", "write addr", 64'(req_addr), 64'h0100);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check("R8", "read follows", 64'(req_valid && !req_write), 64'd1);
    cfg_en = 1'b0;
    clear_all();

    // R9 and R7 overflow: second correctable error while one is pending
    send_rsp(1'b0, 2'd1, 16'h0200, 32'h1111_0200);
    send_rsp(1'b0, 2'd1, 16'h0300, 32'h2222_0300);
    check("R9", "wb addr kept", 64'(req_addr), 64'h0200);
    check("R9", "wb data kept", 64'(req_wdata), 64'h1111_0200);
    check("R7", "first addr kept", 64'(log_addr), 64'h0200);
    check("R7", "overflow set", 64'(log_ovf), 64'd1);
    // R5: snoop while pending cancels it
    snp_wr_valid = 1'b1; snp_wr_addr = 16'h0200;
    @(negedge clk);
    snp_wr_valid = 1'b0;
    check("R5", "late snoop cancels", 64'(req_valid), 64'd0);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    check("R7", "clear valid", 64'(log_valid), 64'd0);
    check("R7", "clear ovf", 64'(log_ovf), 64'd0);

    // R10: mask enables speculative kind only (bit 2)
    cfg_irq_mask = 3'b100;
    send_rsp(1'b0, 2'd2, 16'h0400, 32'h0);
    check("R10", "demand UE masked", 64'(err_irq), 64'd0);
    clear_all();
    send_rsp(1'b1, 2'd2, 16'h0500, 32'h0);
    check("R10", "speculative irq", 64'(err_irq), 64'd1);
    check("R6", "speculative kind", 64'(log_kind), 64'd3);
    clear_all();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule